// File: doc/BRIEF.md
# NOR Flash Command Interface Controller

This block models the command decoder and status logic of a parallel, asynchronous NOR flash with a small register-based array. Bus write cycles carry command bytes plus an address. They choose what later read cycles return: array words, identifier codes or the status byte. They also start a block erase. The erase runs in an internal engine for a fixed, parameterised number of clock cycles. While it runs, a ready/busy pin is driven low.

The status byte has a ready bit and four sticky error flags. The engine sets the flags when a request is refused. They clear only on an explicit clear command or on deep power-down. The programming-voltage sense and the write-protect pin appear as plain digital flags. A read returns status through a latch. The latch captures at the start of each read access, so the value stays fixed while the strobes are held low.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: After `rst`, and whenever `dpd` (deep power-down) is high, the read mode is array. While `dpd` is high, a running erase is aborted without changing the array, the error flags clear, writes are ignored and `rd_data` is 0. At reset, array word `a` holds `a XOR 5A5Ah`.
- R2: A write with `bus_cmd`=FFh selects array mode, 90h selects identifier mode and 70h selects status mode. The mode then holds until another accepted command. Codes that are not listed in R2, R5 or R12 are ignored.
- R3: In identifier mode, a read at address 0 returns `MFR_CODE` and a read at address 1 returns `DEV_CODE`. Any other address returns 0.
- R4: In status mode, `rd_data[7:0]` = {SR7 ready, 0, SR5 erase error, SR4 sequence error, SR3 voltage error, 0, SR1 protect error, 0}, and the upper bits are 0.
- R5: Write 20h, then D0h with an address in the target block (block index = address bits above `WORDS_LOG2`). When the erase completes, every word of that block reads FFFFh and all other blocks are unchanged.
- R6: Writing 20h selects status mode, and so does a confirm that starts an erase. Status mode persists after the erase completes.
- R7: `rdy_busy_n` and SR7 are 0 for exactly `BUSY_CYCLES` clock cycles, starting with the cycle after the clock edge that samples the confirm write.
- R8: While the engine is busy, every write is ignored, FFh included, and the mode stays status.
- R9: If any byte other than D0h follows 20h, SR4 and SR5 are set and no erase starts.
- R10: A confirm with `vpp_ok` low sets SR3 and SR5 and starts no erase. This check takes priority over write-protect.
- R11: A confirm aimed at block `BOOT_BLK` while `wp` is high sets SR1 and SR5 and starts no erase. With `wp` low, that block erases normally.
- R12: Error flags are sticky across all other commands. Writing 50h clears SR5, SR4, SR3 and SR1 and leaves the mode unchanged.
- R13: A read access is active while `ce_n`, `oe_n` and `dpd` are all low. The status value is captured on the first clock of each access and held until the access ends, so a later access is needed to see an update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dpd | input | 1 | Deep power-down request |
| vpp_ok | input | 1 | Programming voltage valid flag |
| wp | input | 1 | Boot-block write-protect active |
| bus_wr | input | 1 | Write cycle strobe, one clock per command |
| bus_cmd | input | 8 | Command byte of the write cycle |
| addr | input | ADDR_W | Word address for reads and erase confirm |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_data | output | DATA_W | Read data |
| rdy_busy_n | output | 1 | High when ready, low while erasing |

## Verification
The bench builds the block with 16-bit words, a 6-bit address split into eight blocks of eight words, boot block 0 and `BUSY_CYCLES`=12. With the busy time this short, the bench can count the exact busy window. It can also fit status reads, ignored commands and a held read access inside one erase, and it has room to see a held access outlast completion. Eight small blocks let it check the words on both sides of an erased block's edges, and they let it aim at the protected boot block.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    typedef enum logic [1:0] {
        MODE_ARRAY  = 2'd0,
        MODE_IDENT  = 2'd1,
        MODE_STATUS = 2'd2
    } rd_mode_e;

    localparam logic [7:0] CMD_RD_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_RD_IDENT  = 8'h90;
    localparam logic [7:0] CMD_RD_STATUS = 8'h70;
    localparam logic [7:0] CMD_CLR_STAT  = 8'h50;
    localparam logic [7:0] CMD_ERA_SETUP = 8'h20;
    localparam logic [7:0] CMD_ERA_CONF  = 8'hD0;

    localparam logic [31:0] INIT_SEED = 32'h5A5A_5A5A;

    typedef struct packed {
        logic era;   // SR5
        logic seq;   // SR4
        logic vpp;   // SR3
        logic prot;  // SR1
    } err_t;

    function automatic logic [7:0] pack_status(input logic ready, input err_t e);
        return {ready, 1'b0, e.era, e.seq, e.vpp, 1'b0, e.prot, 1'b0};
    endfunction

endpackage

// File: rtl/nor_flash_array.sv
module nor_flash_array #(
    parameter int DATA_W     = 16,
    parameter int ADDR_W     = 6,
    parameter int WORDS_LOG2 = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       erase_go,
    input  logic [ADDR_W-WORDS_LOG2-1:0] erase_blk,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_word
);
    import nor_cmd_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst) begin
                mem[i] <= DATA_W'(i) ^ INIT_SEED[DATA_W-1:0];
            end else if (erase_go && ((ADDR_W'(i) >> WORDS_LOG2) == ADDR_W'(erase_blk))) begin
                mem[i] <= '1;
            end
        end
    end

    assign rd_word = mem[rd_addr];

endmodule

// File: rtl/nor_erase_engine.sv
module nor_erase_engine #(
    parameter int BUSY_CYCLES = 64,
    parameter int BLK_W       = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             abort,
    input  logic             start,
    input  logic [BLK_W-1:0] start_blk,
    output logic             busy,
    output logic             erase_go,
    output logic [BLK_W-1:0] erase_blk
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYCLES - 1);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            busy      <= 1'b0;
            remain    <= '0;
            erase_blk <= '0;
        end else if (start) begin
            busy      <= 1'b1;
            remain    <= LOAD;
            erase_blk <= start_blk;
        end else if (busy) begin
            if (remain == '0) begin
                busy <= 1'b0;
            end else begin
                remain <= remain - 1'b1;
            end
        end
    end

    assign erase_go = busy && (remain == '0) && !abort && !rst;

endmodule

// File: rtl/nor_cmd_decode.sv
module nor_cmd_decode #(
    parameter int BLK_W    = 3,
    parameter int BOOT_BLK = 0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   dpd,
    input  logic                   bus_wr,
    input  logic [7:0]             bus_cmd,
    input  logic [BLK_W-1:0]       blk,
    input  logic                   busy,
    input  logic                   vpp_ok,
    input  logic                   wp,
    output nor_cmd_pkg::rd_mode_e  mode,
    output logic                   pend,
    output nor_cmd_pkg::err_t      err,
    output logic                   start,
    output logic [BLK_W-1:0]       start_blk
);
    import nor_cmd_pkg::*;

    localparam logic [BLK_W-1:0] BOOT = BLK_W'(BOOT_BLK);

    logic live_wr;
    logic conf_ok;
    logic boot_locked;

    assign live_wr     = bus_wr && !busy && !dpd && !rst;
    assign conf_ok     = (bus_cmd == CMD_ERA_CONF);
    assign boot_locked = (blk == BOOT) && wp;
    assign start       = live_wr && pend && conf_ok && vpp_ok && !boot_locked;
    assign start_blk   = blk;

    always_ff @(posedge clk) begin
        if (rst || dpd) begin
            mode <= MODE_ARRAY;
            pend <= 1'b0;
            err  <= '0;
        end else if (live_wr) begin
            if (pend) begin
                pend <= 1'b0;
                mode <= MODE_STATUS;
                if (!conf_ok) begin
                    err.seq <= 1'b1;
                    err.era <= 1'b1;
                end else if (!vpp_ok) begin
                    err.vpp <= 1'b1;
                    err.era <= 1'b1;
                end else if (boot_locked) begin
                    err.prot <= 1'b1;
                    err.era  <= 1'b1;
                end
            end else begin
                case (bus_cmd)
                    CMD_RD_ARRAY:  mode <= MODE_ARRAY;
                    CMD_RD_IDENT:  mode <= MODE_IDENT;
                    CMD_RD_STATUS: mode <= MODE_STATUS;
                    CMD_CLR_STAT:  err  <= '0;
                    CMD_ERA_SETUP: begin
                        pend <= 1'b1;
                        mode <= MODE_STATUS;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl #(
    parameter int                 DATA_W      = 16,
    parameter int                 ADDR_W      = 6,
    parameter int                 WORDS_LOG2  = 3,
    parameter int                 BUSY_CYCLES = 64,
    parameter int                 BOOT_BLK    = 0,
    parameter logic [DATA_W-1:0]  MFR_CODE    = DATA_W'(16'h00B0),
    parameter logic [DATA_W-1:0]  DEV_CODE    = DATA_W'(16'h0049)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dpd,
    input  logic              vpp_ok,
    input  logic              wp,
    input  logic              bus_wr,
    input  logic [7:0]        bus_cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              oe_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              rdy_busy_n
);
    import nor_cmd_pkg::*;

    localparam int BLK_W = ADDR_W - WORDS_LOG2;

    rd_mode_e          mode_w;
    logic              pend_w;
    err_t              err_w;
    logic              start_w;
    logic [BLK_W-1:0]  start_blk_w;
    logic              busy_w;
    logic              erase_go_w;
    logic [BLK_W-1:0]  erase_blk_w;
    logic [DATA_W-1:0] arr_word_w;

    nor_cmd_decode #(.BLK_W(BLK_W), .BOOT_BLK(BOOT_BLK)) u_dec (
        .clk       (clk),
        .rst       (rst),
        .dpd       (dpd),
        .bus_wr    (bus_wr),
        .bus_cmd   (bus_cmd),
        .blk       (addr[ADDR_W-1:WORDS_LOG2]),
        .busy      (busy_w),
        .vpp_ok    (vpp_ok),
        .wp        (wp),
        .mode      (mode_w),
        .pend      (pend_w),
        .err       (err_w),
        .start     (start_w),
        .start_blk (start_blk_w)
    );

    nor_erase_engine #(.BUSY_CYCLES(BUSY_CYCLES), .BLK_W(BLK_W)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .abort     (dpd),
        .start     (start_w),
        .start_blk (start_blk_w),
        .busy      (busy_w),
        .erase_go  (erase_go_w),
        .erase_blk (erase_blk_w)
    );

    nor_flash_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WORDS_LOG2(WORDS_LOG2)) u_arr (
        .clk       (clk),
        .rst       (rst),
        .erase_go  (erase_go_w),
        .erase_blk (erase_blk_w),
        .rd_addr   (addr),
        .rd_word   (arr_word_w)
    );

    // Status latch: captured on the first clock of each read access.
    logic       rd_act;
    logic       rd_act_q;
    logic [7:0] sr_live;
    logic [7:0] sr_hold;
    logic [7:0] sr_shown;

    assign rd_act   = !ce_n && !oe_n && !dpd;
    assign sr_live  = pack_status(!busy_w, err_w);
    assign sr_shown = (rd_act && !rd_act_q) ? sr_live : sr_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_act_q <= 1'b0;
            sr_hold  <= 8'h00;
        end else begin
            rd_act_q <= rd_act;
            if (rd_act && !rd_act_q) begin
                sr_hold <= sr_live;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_act) begin
            case (mode_w)
                MODE_ARRAY:  rd_data = arr_word_w;
                MODE_IDENT: begin
                    if (addr == '0) begin
                        rd_data = MFR_CODE;
                    end else if (addr == ADDR_W'(1)) begin
                        rd_data = DEV_CODE;
                    end
                end
                MODE_STATUS: rd_data = DATA_W'(sr_shown);
                default:     rd_data = '0;
            endcase
        end
    end

    assign rdy_busy_n = !busy_w;

endmodule

// File: rtl/nor_cmd_ctrl_chk.sv
module nor_cmd_ctrl_chk #(
    parameter int BUSY_CYCLES = 64,
    parameter int DATA_W      = 16
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  dpd,
    input logic                  bus_wr,
    input logic [7:0]            bus_cmd,
    input logic                  ce_n,
    input logic                  oe_n,
    input logic [DATA_W-1:0]     rd_data,
    input logic                  rdy_busy_n,
    input nor_cmd_pkg::rd_mode_e mode,
    input logic                  pend,
    input nor_cmd_pkg::err_t     err
);
    import nor_cmd_pkg::*;

    logic rd_act;
    int   low_cnt;

    assign rd_act = !ce_n && !oe_n && !dpd;

    always_ff @(posedge clk) begin
        if (rst || rdy_busy_n) begin
            low_cnt <= 0;
        end else begin
            low_cnt <= low_cnt + 1;
        end
    end

    // R1: reset leaves array mode
    p_reset_array_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> mode == MODE_ARRAY);

    // R7: busy window length
    p_busy_len_r7: assert property (@(posedge clk) disable iff (rst)
        ($rose(rdy_busy_n) && !$past(dpd)) |-> low_cnt == BUSY_CYCLES);

    // R8: writes during busy leave status mode in place
    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (rst)
        (!rdy_busy_n && bus_wr && !dpd) |=> mode == MODE_STATUS);

    // R9: bad confirm sets both flags
    p_bad_confirm_r9: assert property (@(posedge clk) disable iff (rst)
        (pend && bus_wr && !dpd && bus_cmd != CMD_ERA_CONF) |=> (err.seq && err.era));

    // R12: flags fall only on clear command or power-down
    p_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        (($past(err) & ~err) != 4'b0) |-> ($past(bus_wr && bus_cmd == CMD_CLR_STAT) || $past(dpd)));

    // R13: held access shows a frozen status value
    p_latch_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (rd_act && $past(rd_act) && mode == MODE_STATUS && $past(mode) == MODE_STATUS)
        |-> $stable(rd_data));

endmodule

bind nor_cmd_ctrl nor_cmd_ctrl_chk #(.BUSY_CYCLES(BUSY_CYCLES), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .dpd        (dpd),
    .bus_wr     (bus_wr),
    .bus_cmd    (bus_cmd),
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .rd_data    (rd_data),
    .rdy_busy_n (rdy_busy_n),
    .mode       (mode_w),
    .pend       (pend_w),
    .err        (err_w)
);

// File: tb/nor_cmd_ctrl_tb.sv
module nor_cmd_ctrl_tb;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 6;
    localparam int BUSY_N = 12;
    localparam logic [15:0] MFR = 16'h00B0;
    localparam logic [15:0] DEV = 16'h0049;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              dpd = 1'b0;
    logic              vpp_ok = 1'b1;
    logic              wp = 1'b0;
    logic              bus_wr = 1'b0;
    logic [7:0]        bus_cmd = 8'h00;
    logic [ADDR_W-1:0] addr = '0;
    logic              ce_n = 1'b1;
    logic              oe_n = 1'b1;
    logic [DATA_W-1:0] rd_data;
    logic              rdy_busy_n;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];

    always #5 clk = ~clk;

    nor_cmd_ctrl #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WORDS_LOG2(3),
        .BUSY_CYCLES(BUSY_N), .BOOT_BLK(0),
        .MFR_CODE(MFR), .DEV_CODE(DEV)
    ) u_dut (
        .clk(clk), .rst(rst), .dpd(dpd), .vpp_ok(vpp_ok), .wp(wp),
        .bus_wr(bus_wr), .bus_cmd(bus_cmd), .addr(addr),
        .ce_n(ce_n), .oe_n(oe_n), .rd_data(rd_data), .rdy_busy_n(rdy_busy_n)
    );

    function automatic logic [15:0] init_word(input int a);
        return 16'(a) ^ 16'h5A5A;
    endfunction

    // Monitor: compares read data against queued expectations.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_run++;
                if (rd_data !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: rd_data=%h expected=%h", it.tag, rd_data, it.exp);
                end
            end
        end
    end

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] c, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        bus_cmd = c;
        addr    = a;
        bus_wr  = 1'b1;
        @(negedge clk);
        bus_wr  = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [15:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        addr = a;
        ce_n = 1'b0;
        oe_n = 1'b0;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk);
        #3;
        @(negedge clk);
        ce_n = 1'b1;
        oe_n = 1'b1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int cnt;
        item_t it;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check(16'(rdy_busy_n), 16'h1, "R1 ready after reset");
        rd(6'd5, init_word(5), "R1 array mode after reset");

        // R3: identifier codes
        wr(8'h90, 6'd0);
        rd(6'd0, MFR, "R3 manufacturer code");
        rd(6'd1, DEV, "R3 device code");
        rd(6'd2, 16'h0000, "R3 other address");

        // R2: unknown code ignored, mode persists
        wr(8'h33, 6'd0);
        rd(6'd0, MFR, "R2 unknown code ignored");
        wr(8'hFF, 6'd0);
        rd(6'd9, init_word(9), "R2 back to array");

        // R4: status layout, ready only
        wr(8'h70, 6'd0);
        rd(6'd0, 16'h0080, "R4 idle status");

        // R9: bad confirm
        wr(8'h20, 6'h10);
        rd(6'd0, 16'h0080, "R6 status after setup");
        wr(8'h77, 6'h10);
        rd(6'd0, 16'h00B0, "R9 sequence error flags");

        // R12: sticky across commands, clear keeps mode
        wr(8'h90, 6'd0);
        wr(8'h70, 6'd0);
        rd(6'd0, 16'h00B0, "R12 flags sticky");
        wr(8'h50, 6'd0);
        rd(6'd0, 16'h0080, "R12 cleared, still status");
        wr(8'hFF, 6'd0);
        rd(6'h10, init_word(16), "R9 no erase after bad confirm");

        // R10: voltage error, priority over protect
        vpp_ok = 1'b0;
        wr(8'h20, 6'h11);
        wr(8'hD0, 6'h11);
        rd(6'd0, 16'h00A8, "R10 voltage error");
        wr(8'h50, 6'd0);
        wp = 1'b1;
        wr(8'h20, 6'h01);
        wr(8'hD0, 6'h01);
        rd(6'd0, 16'h00A8, "R10 voltage beats protect");
        vpp_ok = 1'b1;
        wr(8'h50, 6'd0);

        // R11: protected boot block
        wr(8'h20, 6'h02);
        wr(8'hD0, 6'h02);
        check(16'(rdy_busy_n), 16'h1, "R11 no start when protected");
        rd(6'd0, 16'h00A2, "R11 protect error");
        wr(8'h50, 6'd0);
        wr(8'hFF, 6'd0);
        rd(6'h02, init_word(2), "R11 boot block unchanged");

        // R5/R7: erase block 2, count busy window
        wr(8'h20, 6'h13);
        wr(8'hD0, 6'h13);
        cnt = 0;
        while (rdy_busy_n == 1'b0 && cnt < 1000) begin
            cnt++;
            @(negedge clk);
        end
        check(16'(cnt), 16'(BUSY_N), "R7 busy cycle count");
        rd(6'd0, 16'h0080, "R6 status persists after erase");
        wr(8'hFF, 6'd0);
        rd(6'h10, 16'hFFFF, "R5 first word erased");
        rd(6'h17, 16'hFFFF, "R5 last word erased");
        rd(6'h18, init_word(24), "R5 next block kept");
        rd(6'h0F, init_word(15), "R5 previous block kept");

        // R11: boot block erases with protect off
        wp = 1'b0;
        wr(8'h20, 6'h00);
        wr(8'hD0, 6'h00);
        while (rdy_busy_n == 1'b0) @(negedge clk);
        wr(8'hFF, 6'd0);
        rd(6'h05, 16'hFFFF, "R11 boot block erased when unprotected");

        // R8/R13: activity during busy, held read across completion
        wr(8'h20, 6'h1A);
        wr(8'hD0, 6'h1A);
        rd(6'd0, 16'h0000, "R7 busy status");
        wr(8'hFF, 6'd0);
        rd(6'h1A, 16'h0000, "R8 read-array ignored while busy");
        wr(8'h50, 6'd0);
        @(negedge clk);
        ce_n = 1'b0;
        oe_n = 1'b0;
        it.exp = 16'h0000;
        it.tag = "R13 captured at access start";
        sb_q.push_back(it);
        while (rdy_busy_n == 1'b0) @(negedge clk);
        @(negedge clk);
        it.exp = 16'h0000;
        it.tag = "R13 held across completion";
        sb_q.push_back(it);
        @(posedge clk);
        #3;
        @(negedge clk);
        ce_n = 1'b1;
        oe_n = 1'b1;
        rd(6'd0, 16'h0080, "R13 new access shows update");
        wr(8'hFF, 6'd0);
        rd(6'h1B, 16'hFFFF, "R5 block 3 erased");

        // R1: deep power-down aborts erase
        wr(8'h20, 6'h20);
        wr(8'hD0, 6'h20);
        wr(8'h20, 6'h00);
        @(negedge clk);
        dpd = 1'b1;
        rd(6'h20, 16'h0000, "R1 no data in power-down");
        check(16'(rdy_busy_n), 16'h1, "R1 power-down aborts erase");
        @(negedge clk);
        dpd = 1'b0;
        rd(6'h20, init_word(32), "R1 array mode after power-down");
        wr(8'h70, 6'd0);
        rd(6'd0, 16'h0080, "R1 status clean after power-down");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule